// File: doc/BRIEF.md
# In-frame response transmit sequencer

This block sends a software-fed, multi-byte response inside a frame on a multiplexed serial vehicle bus. Software arms the response and places the first byte in a one-byte data holding register. When the receive side reports that the frame's end-of-data symbol has been seen, the sequencer starts. It sends a normalization symbol and then the held byte, most significant bit first. Each time the holding register is moved into the shift register, an empty flag rises so that software can supply the next byte. When software marks the last byte, the sequencer finishes the byte in progress, appends an inverted CRC-8 byte and closes with an end-of-data symbol.

Pulse-width timing is not handled here. Every symbol goes to an abstract symbol encoder through a request/done handshake. At each completed data bit the encoder returns the bus level it sampled, and the sequencer uses it for bitwise arbitration. The response is abandoned on a bus error, on a data underrun or on lost arbitration. If arbitration is lost in the last two bit positions of a byte, two extra logic-1 bits are still sent before the bus is released.

Top module: `ifr_tx_seq`

## Requirements
- R1: After reset `sym_req_o` is low and `armed_o`, `eod_pend_o`, `tde_o`, `lost_o` and `err_o` are all 0.
- R2: With `armed_o` = 1, a pulse on `rx_eod_i` starts the response. The symbols are sent in this order: first a normalization symbol (`sym_kind_o` = 0), then the held byte as data-bit symbols (`sym_kind_o` = 1, value on `sym_bit_o`), most significant bit first. Each `sym_done_i` completes exactly one symbol.
- R3: `tde_o` rises in the cycle after the held byte is moved into the shift register. A `wr_data_i` write clears it, and so does writing 1 to `clr_flags_i[0]`.
- R4: When `eod_pend_o` is 1 at the end of a byte, the next 8 data-bit symbols carry the inverted CRC-8, most significant bit first. The CRC uses polynomial 0x1D, starts from 0xFF and covers the response bytes only. An end-of-data symbol (`sym_kind_o` = 2) follows. After it completes, `sym_req_o`, `armed_o` and `eod_pend_o` are 0.
- R5: If `set_eod_i` is pulsed after the first empty flag of a response, that first byte is the only byte before the CRC, and `tde_o` does not rise again in that response.
- R6: An underrun aborts the response: `err_o` is set, `armed_o` is cleared, `sym_req_o` drops and no CRC is sent. An underrun occurs when a byte finishes with no new byte written and `eod_pend_o` = 0, or when the holding register is empty as the normalization symbol completes.
- R7: A `set_arm_i` pulse in the cycle of `rx_eod_i` or in the following `LATE_WIN` cycles is ignored, and `armed_o` stays 0.
- R8: Lost arbitration means a data or CRC bit sent as 1 is sampled back as 0. When it happens at bit positions 0 to W-3, `sym_req_o` drops, `lost_o` is set and `armed_o` is cleared. The byte is not retransmitted.
- R9: When lost arbitration happens at bit position W-2 or W-1, `lost_o` is set and `armed_o` is cleared, but exactly two more data-bit symbols of value 1 are sent before `sym_req_o` drops.
- R10: `bus_err_i` during an active response ends it in the next cycle, sets `err_o` and clears `armed_o`.
- R11: While `sym_req_o` is high and `sym_done_i` is low, `sym_kind_o` and `sym_bit_o` hold their values.
- R12: Writing 1 to `clr_flags_i` clears the flags bit by bit: bit 0 clears `tde_o`, bit 1 clears `lost_o`, bit 2 clears `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_data_i | input | 1 | Write strobe for the data holding register |
| data_i | input | W | Byte to hold |
| set_arm_i | input | 1 | Request to arm a response |
| set_eod_i | input | 1 | Mark the held/current byte as the last |
| clr_flags_i | input | 3 | Write-1-to-clear: [0] empty, [1] lost, [2] error |
| rx_eod_i | input | 1 | End-of-data symbol received from the bus |
| sym_req_o | output | 1 | Symbol request to the encoder |
| sym_kind_o | output | 2 | 0 normalization, 1 data bit, 2 end-of-data |
| sym_bit_o | output | 1 | Data-bit value for kind 1 |
| sym_done_i | input | 1 | Encoder completed the requested symbol |
| bus_bit_i | input | 1 | Bus level sampled at symbol completion |
| bus_err_i | input | 1 | Bus error detected |
| armed_o | output | 1 | Response enabled |
| eod_pend_o | output | 1 | Last byte marked |
| tde_o | output | 1 | Holding register empty flag |
| lost_o | output | 1 | Lost-arbitration flag |
| err_o | output | 1 | Error/underrun flag |

## Verification
The bench uses the default parameters: W = 8, LATE_WIN = 2, LATE_ZONE = 2 and TAIL_BITS = 2. With an 8-bit byte, the early-loss positions and the two late positions (6 and 7) are both only a few symbols into a response. With a window of two cycles, the bench can test the ignored arm requests and the first cycle in which arming is accepted back to back. The reference model builds the expected symbol stream and the CRC from the byte values alone. It then compares the symbol interface on every clock of each handshake.

// File: rtl/ifr_pkg.sv
`timescale 1ns/1ps
package ifr_pkg;
   typedef enum logic [1:0] {SK_NORM = 2'd0, SK_BIT = 2'd1, SK_EOD = 2'd2} sym_kind_t;
   typedef enum logic [2:0] {ST_IDLE, ST_NORM, ST_DATA, ST_CRC, ST_EOD, ST_TAIL} seq_st_t;
endpackage

// File: rtl/ifr_late_guard.sv
`timescale 1ns/1ps
module ifr_late_guard #(
   parameter int WIN = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eod_seen_i,
   output logic block_o
);
   generate
      if (WIN == 0) begin : g_none
         assign block_o = eod_seen_i;
      end else begin : g_cnt
         localparam int CW = $clog2(WIN + 1);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               cnt_q <= '0;
            else if (eod_seen_i)      cnt_q <= CW'(WIN);
            else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
         end
         assign block_o = eod_seen_i || (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/ifr_bit_shifter.sv
`timescale 1ns/1ps
module ifr_bit_shifter #(
   parameter int W = 8,
   localparam int IW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [W-1:0]  val_i,
   input  logic          shift_i,
   output logic          msb_o,
   output logic          last_o,
   output logic [IW-1:0] idx_o
);
   logic [W-1:0]  sh_q;
   logic [IW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q  <= '0;
         idx_q <= '0;
      end else if (load_i) begin
         sh_q  <= val_i;
         idx_q <= '0;
      end else if (shift_i) begin
         sh_q  <= {sh_q[W-2:0], 1'b0};
         idx_q <= idx_q + 1'b1;
      end
   end

   assign msb_o  = sh_q[W-1];
   assign last_o = (idx_q == IW'(W - 1));
   assign idx_o  = idx_q;
endmodule

// File: rtl/ifr_crc_ser.sv
`timescale 1ns/1ps
module ifr_crc_ser #(
   parameter int          CW      = 8,
   parameter logic [CW-1:0] POLY  = 8'h1D,
   parameter logic [CW-1:0] INIT  = 8'hFF,
   parameter bit          INV_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_i,
   input  logic          en_i,
   input  logic          bit_i,
   output logic [CW-1:0] tx_o
);
   logic [CW-1:0] crc_q, nxt;
   logic          fb;

   assign fb = crc_q[CW-1] ^ bit_i;

   generate
      for (genvar k = 0; k < CW; k++) begin : g_tap
         if (k == 0) begin : g_lsb
            assign nxt[k] = POLY[k] & fb;
         end else begin : g_up
            assign nxt[k] = crc_q[k-1] ^ (POLY[k] & fb);
         end
      end
      if (INV_OUT) begin : g_inv
         assign tx_o = ~nxt;
      end else begin : g_plain
         assign tx_o = nxt;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= INIT;
      else if (init_i) crc_q <= INIT;
      else if (en_i)   crc_q <= nxt;
   end
endmodule

// File: rtl/ifr_tx_seq.sv
`timescale 1ns/1ps
module ifr_tx_seq
   import ifr_pkg::*;
#(
   parameter int          W         = 8,
   parameter logic [W-1:0] CRC_POLY = 8'h1D,
   parameter logic [W-1:0] CRC_INIT = 8'hFF,
   parameter int          LATE_WIN  = 2,
   parameter int          LATE_ZONE = 2,
   parameter int          TAIL_BITS = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_data_i,
   input  logic [W-1:0] data_i,
   input  logic         set_arm_i,
   input  logic         set_eod_i,
   input  logic [2:0]   clr_flags_i,
   input  logic         rx_eod_i,
   output logic         sym_req_o,
   output logic [1:0]   sym_kind_o,
   output logic         sym_bit_o,
   input  logic         sym_done_i,
   input  logic         bus_bit_i,
   input  logic         bus_err_i,
   output logic         armed_o,
   output logic         eod_pend_o,
   output logic         tde_o,
   output logic         lost_o,
   output logic         err_o
);
   localparam int IW = $clog2(W);
   localparam int TW = $clog2(TAIL_BITS + 1);

   generate
      if (W < 2) begin : g_bad_w
         $error("ifr_tx_seq: W must be at least 2");
      end
      if (LATE_ZONE < 0 || LATE_ZONE > W) begin : g_bad_zone
         $error("ifr_tx_seq: LATE_ZONE out of range");
      end
      if (TAIL_BITS < 1) begin : g_bad_tail
         $error("ifr_tx_seq: TAIL_BITS must be positive");
      end
   endgenerate

   seq_st_t        st_q, st_d;
   logic           arm_q, eod_q, full_q, tde_q, lost_q, err_q;
   logic [W-1:0]   dreg_q;
   logic [TW-1:0]  tail_q, tail_d;
   logic           arm_block;
   logic           sh_load, sh_shift, sh_msb, sh_last;
   logic [W-1:0]   sh_val;
   logic [IW-1:0]  sh_idx;
   logic           crc_init, crc_en;
   logic [W-1:0]   crc_tx;
   logic           take, fin, set_lost, set_err;
   logic           active, done, drv_bit, lost_now, late_pos;

   ifr_late_guard #(.WIN(LATE_WIN)) u_guard (
      .clk(clk), .rst_n(rst_n), .eod_seen_i(rx_eod_i), .block_o(arm_block));

   ifr_bit_shifter #(.W(W)) u_shift (
      .clk(clk), .rst_n(rst_n), .load_i(sh_load), .val_i(sh_val),
      .shift_i(sh_shift), .msb_o(sh_msb), .last_o(sh_last), .idx_o(sh_idx));

   ifr_crc_ser #(.CW(W), .POLY(CRC_POLY), .INIT(CRC_INIT), .INV_OUT(1'b1)) u_crc (
      .clk(clk), .rst_n(rst_n), .init_i(crc_init), .en_i(crc_en),
      .bit_i(sh_msb), .tx_o(crc_tx));

   assign active   = (st_q != ST_IDLE);
   assign done     = sym_done_i && active;
   assign drv_bit  = (st_q == ST_TAIL) ? 1'b1 : sh_msb;
   assign lost_now = done && (st_q == ST_DATA || st_q == ST_CRC) && drv_bit && !bus_bit_i;
   assign late_pos = (int'(sh_idx) >= W - LATE_ZONE);

   always_comb begin
      st_d     = st_q;
      tail_d   = tail_q;
      sh_load  = 1'b0;
      sh_val   = dreg_q;
      sh_shift = 1'b0;
      crc_init = 1'b0;
      crc_en   = 1'b0;
      take     = 1'b0;
      fin      = 1'b0;
      set_lost = 1'b0;
      set_err  = 1'b0;
      unique case (st_q)
         ST_IDLE: if (arm_q && rx_eod_i) st_d = ST_NORM;
         ST_NORM: if (done) begin
            if (full_q) begin
               sh_load  = 1'b1;
               take     = 1'b1;
               crc_init = 1'b1;
               st_d     = ST_DATA;
            end else begin
               set_err = 1'b1;
               fin     = 1'b1;
               st_d    = ST_IDLE;
            end
         end
         ST_DATA, ST_CRC: if (lost_now) begin
            set_lost = 1'b1;
            fin      = 1'b1;
            tail_d   = '0;
            st_d     = late_pos ? ST_TAIL : ST_IDLE;
         end else if (done) begin
            sh_shift = 1'b1;
            crc_en   = (st_q == ST_DATA);
            if (sh_last && st_q == ST_CRC) begin
               st_d = ST_EOD;
            end else if (sh_last) begin
               if (eod_q) begin
                  sh_load = 1'b1;
                  sh_val  = crc_tx;
                  st_d    = ST_CRC;
               end else if (full_q) begin
                  sh_load = 1'b1;
                  take    = 1'b1;
               end else begin
                  set_err = 1'b1;
                  fin     = 1'b1;
                  st_d    = ST_IDLE;
               end
            end
         end
         ST_EOD: if (done) begin
            fin  = 1'b1;
            st_d = ST_IDLE;
         end
         ST_TAIL: if (done) begin
            tail_d = tail_q + 1'b1;
            if (tail_q == TW'(TAIL_BITS - 1)) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
      if (active && bus_err_i) begin
         st_d     = ST_IDLE;
         set_err  = 1'b1;
         fin      = 1'b1;
         set_lost = 1'b0;
         take     = 1'b0;
         sh_load  = 1'b0;
         sh_shift = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         tail_q <= '0;
         arm_q  <= 1'b0;
         eod_q  <= 1'b0;
         full_q <= 1'b0;
         dreg_q <= '0;
         tde_q  <= 1'b0;
         lost_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         tail_q <= tail_d;
         if (fin)                          arm_q <= 1'b0;
         else if (set_arm_i && !arm_block) arm_q <= 1'b1;
         if (fin)                          eod_q <= 1'b0;
         else if (set_eod_i && arm_q)      eod_q <= 1'b1;
         if (fin || take)                  full_q <= 1'b0;
         if (wr_data_i) begin
            full_q <= 1'b1;
            dreg_q <= data_i;
         end
         if (clr_flags_i[0]) tde_q <= 1'b0;
         if (take)           tde_q <= 1'b1;
         if (wr_data_i)      tde_q <= 1'b0;
         if (clr_flags_i[1]) lost_q <= 1'b0;
         if (set_lost)       lost_q <= 1'b1;
         if (clr_flags_i[2]) err_q <= 1'b0;
         if (set_err)        err_q <= 1'b1;
      end
   end

   assign sym_req_o  = active;
   assign sym_kind_o = (st_q == ST_NORM) ? SK_NORM : (st_q == ST_EOD) ? SK_EOD : SK_BIT;
   assign sym_bit_o  = (st_q == ST_NORM || st_q == ST_EOD || st_q == ST_IDLE) ? 1'b0 : drv_bit;
   assign armed_o    = arm_q;
   assign eod_pend_o = eod_q;
   assign tde_o      = tde_q;
   assign lost_o     = lost_q;
   assign err_o      = err_q;
endmodule

// File: rtl/ifr_tx_seq_chk.sv
`timescale 1ns/1ps
module ifr_tx_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rx_eod_i,
   input logic       wr_data_i,
   input logic       sym_req_o,
   input logic [1:0] sym_kind_o,
   input logic       sym_bit_o,
   input logic       sym_done_i,
   input logic       bus_err_i,
   input logic       armed_o,
   input logic       tde_o,
   input logic       lost_o,
   input logic       err_o
);
   // R11
   sym_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_req_o && !sym_done_i && !bus_err_i |=> sym_req_o && $stable(sym_kind_o) && $stable(sym_bit_o));
   // R7
   late_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_eod_i && !armed_o |=> !armed_o);
   // R8
   lost_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lost_o) |-> !armed_o);
   // R9
   tail_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_req_o && !armed_o |-> sym_kind_o == 2'd1 && sym_bit_o);
   // R4
   eod_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_req_o && sym_kind_o == 2'd2 && sym_done_i && !bus_err_i |=> !sym_req_o && !armed_o);
   // R10
   err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sym_req_o && bus_err_i |=> !sym_req_o && err_o && !armed_o);
   // R3
   tde_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data_i |=> !tde_o);
endmodule

bind ifr_tx_seq ifr_tx_seq_chk u_chk (.*);

// File: tb/tb_ifr_tx_seq.sv
`timescale 1ns/1ps
module tb_ifr_tx_seq;
   localparam int W = 8;

   logic         clk = 1'b0, rst_n = 1'b0;
   logic         wr_data_i = 0, set_arm_i = 0, set_eod_i = 0, rx_eod_i = 0;
   logic [W-1:0] data_i = '0;
   logic [2:0]   clr_flags_i = '0;
   logic         sym_done_i = 0, bus_bit_i = 1, bus_err_i = 0;
   logic         sym_req_o, sym_bit_o, armed_o, eod_pend_o, tde_o, lost_o, err_o;
   logic [1:0]   sym_kind_o;

   int vectors = 0, miscompares = 0;
   bit finished = 0;
   int expq[$];

   always #2.5 clk = ~clk;

   ifr_tx_seq dut (.*);

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   // expected symbol codes: kind*2 + bit
   function automatic int cur_code();
      return sym_req_o ? (int'(sym_kind_o) * 2 + int'(sym_bit_o)) : -1;
   endfunction

   task automatic push_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) expq.push_back(2 + int'(b[i]));
   endtask

   function automatic logic [7:0] crc_of(input logic [7:0] bytes[$]);
      logic [7:0] c = 8'hFF;
      foreach (bytes[j])
         for (int i = 7; i >= 0; i--) begin
            logic f = c[7] ^ bytes[j][i];
            c = {c[6:0], 1'b0};
            if (f) c = c ^ 8'h1D;
         end
      return ~c;
   endfunction

   // reference-driven encoder: each symbol checked over two clocks, then completed
   task automatic serve(input int n, input int lose);
      for (int i = 0; i < n; i++) begin
         int e = (expq.size() > 0) ? expq[0] : -1;
         chk(cur_code() == e, "R11 symbol held", cur_code(), e);
         @(negedge clk);
         chk(cur_code() == e, "R2 symbol order", cur_code(), e);
         sym_done_i = 1;
         bus_bit_i  = (i == lose) ? 1'b0 : sym_bit_o;
         void'(expq.pop_front());
         @(negedge clk);
         sym_done_i = 0;
         bus_bit_i  = 1;
      end
   endtask

   task automatic t_wr(input logic [7:0] b);
      data_i = b; wr_data_i = 1; @(negedge clk); wr_data_i = 0;
   endtask
   task automatic t_arm();    set_arm_i = 1; @(negedge clk); set_arm_i = 0; endtask
   task automatic t_eod();    set_eod_i = 1; @(negedge clk); set_eod_i = 0; endtask
   task automatic t_rxeod();  rx_eod_i = 1;  @(negedge clk); rx_eod_i = 0;  endtask
   task automatic t_clr(input logic [2:0] m); clr_flags_i = m; @(negedge clk); clr_flags_i = '0; endtask

   initial begin
      repeat (20000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      logic [7:0] bl[$];
      logic [7:0] c;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!sym_req_o, "R1 req", sym_req_o, 0);
      chk({armed_o, eod_pend_o, tde_o, lost_o, err_o} == 5'b0, "R1 flags",
          {armed_o, eod_pend_o, tde_o, lost_o, err_o}, 0);

      // three-byte response
      t_wr(8'hA5); t_arm(); t_rxeod();
      expq.push_back(0);
      serve(1, -1);
      chk(tde_o, "R3 empty after load", tde_o, 1);
      t_wr(8'h3C);
      chk(!tde_o, "R3 write clears empty", tde_o, 0);
      push_byte(8'hA5); serve(8, -1);
      chk(tde_o, "R3 empty after second load", tde_o, 1);
      t_wr(8'hF0);
      push_byte(8'h3C); serve(8, -1);
      t_clr(3'b001);
      chk(!tde_o, "R12 clear empty flag", tde_o, 0);
      t_eod();
      bl = {8'hA5, 8'h3C, 8'hF0}; c = crc_of(bl);
      push_byte(8'hF0); push_byte(c); expq.push_back(4);
      serve(17, -1);
      chk(!sym_req_o && !armed_o && !eod_pend_o, "R4 closed after end symbol",
          {sym_req_o, armed_o, eod_pend_o}, 0);
      chk(!tde_o, "R4 no load after last byte", tde_o, 0);

      // single-byte response
      t_wr(8'h11); t_arm(); t_rxeod();
      expq.push_back(0); serve(1, -1);
      chk(tde_o, "R5 first empty flag", tde_o, 1);
      t_clr(3'b001); t_eod();
      bl = {8'h11}; c = crc_of(bl);
      push_byte(8'h11); push_byte(c); expq.push_back(4);
      serve(17, -1);
      chk(!tde_o, "R5 no second empty flag", tde_o, 0);
      chk(!sym_req_o && !armed_o, "R5 closed", {sym_req_o, armed_o}, 0);

      // underrun
      t_wr(8'h5A); t_arm(); t_rxeod();
      expq.push_back(0); serve(1, -1);
      push_byte(8'h5A); serve(8, -1);
      chk(err_o && !armed_o && !sym_req_o, "R6 underrun abort",
          {err_o, armed_o, sym_req_o}, 3'b100);
      t_clr(3'b100);
      chk(!err_o, "R12 clear error flag", err_o, 0);

      // late arm window
      set_arm_i = 1; rx_eod_i = 1; @(negedge clk); set_arm_i = 0; rx_eod_i = 0;
      chk(!armed_o, "R7 arm with end symbol ignored", armed_o, 0);
      t_arm();
      chk(!armed_o, "R7 arm one cycle later ignored", armed_o, 0);
      t_arm();
      chk(!armed_o, "R7 arm two cycles later ignored", armed_o, 0);
      t_arm();
      chk(armed_o, "R7 arm after window accepted", armed_o, 1);

      // early lost arbitration at bit position 2
      t_wr(8'hFF); t_rxeod();
      expq.push_back(0); expq.push_back(3); expq.push_back(3); expq.push_back(3);
      serve(4, 3);
      chk(!sym_req_o && lost_o && !armed_o, "R8 early loss stops",
          {sym_req_o, lost_o, armed_o}, 3'b010);
      repeat (3) @(negedge clk);
      chk(!sym_req_o, "R8 no retransmit", sym_req_o, 0);
      t_clr(3'b010);
      chk(!lost_o, "R12 clear lost flag", lost_o, 0);

      // late lost arbitration at bit position 6
      t_arm(); t_wr(8'hFF); t_rxeod();
      expq.push_back(0);
      for (int i = 0; i < 9; i++) expq.push_back(3);
      serve(10, 7);
      chk(!sym_req_o && lost_o && !armed_o, "R9 two extra ones then release",
          {sym_req_o, lost_o, armed_o}, 3'b010);
      t_clr(3'b111);

      // bus error mid byte
      t_arm(); t_wr(8'h81); t_rxeod();
      expq.push_back(0); expq.push_back(3); expq.push_back(2);
      serve(3, -1);
      bus_err_i = 1; @(negedge clk); bus_err_i = 0;
      chk(!sym_req_o && err_o && !armed_o, "R10 bus error abort",
          {sym_req_o, err_o, armed_o}, 3'b010);
      expq.delete();

      repeat (2) @(negedge clk);
      summary();
   end
endmodule